// File: doc/BRIEF.md
# Cache Victim Way Selector

This block picks the way to evict when a set-associative cache with one to four ways misses. It holds a small amount of history for every cache line, addressed by the line index, and turns that history into a victim way for the line named on the query index. The tag and data arrays, hit detection and refill stay outside. The surrounding cache reports each hit with its way and each fill with its way. It also supplies the per-way lock bits of the line being queried.

The replacement policy is a parameter. Pseudo-random rotates a free-running counter. Least-recently-replaced works with two ways only and evicts the way that was not filled last. True least-recently-used keeps an exact recency order per line. That order is packed into 1, 3 or 5 bits for 2, 3 or 4 ways, and a hit or a fill moves the way it names to most recent. A lock-aware stage then steps along the policy's preference order and skips locked ways. If every way is locked, it returns the policy's first choice and raises a flag.

The victim output is combinational from the stored history, the query index and the lock bits. History changes on the clock edge that samples a hit or fill strobe. The reset is asynchronous and active low.

Top module: `victim_sel`

## Requirements
- R1: While reset is asserted, and after it is released with no accesses since, every line returns victim way 0 in every policy. In LRU mode each line's order is way 0 least recent up to the highest way most recent. The random counter restarts at 0.
- R2: In LRU mode the victim is the least recently accessed unlocked way of the queried line, and both a hit strobe and a fill strobe count as an access to the way they name.
- R3: In LRU mode, a hit and a fill that name the same line in the same cycle are both applied, and the fill counts as the more recent access.
- R4: A hit or fill changes only the history of the line it names. Any other line keeps its victim.
- R5: Lock bit w of lock_i locks way w (ways are numbered in binary 0..NUM_WAYS-1). A locked way is never returned while the queried line has an unlocked way. The first unlocked way in the policy's preference order is returned instead.
- R6: When every lock bit is set, all_locked_o is 1 and the victim is the policy's unlocked-case first choice. Otherwise all_locked_o is 0.
- R7: In least-recently-replaced mode (two ways only) the victim is the way other than the one most recently filled into that line. Hit strobes have no effect.
- R8: In random mode a counter advances by one every clock. With three ways it wraps 0, 1, 2, 0 and never yields way 3. With no locks the victim equals the counter, and a locked way is skipped cyclically to the next higher unlocked way.
- R9: With a single way the victim is always way 0 and no history is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hit_valid_i | input | 1 | Hit strobe for one cycle |
| hit_idx_i | input | IDX_W | Line index of the hit |
| hit_way_i | input | 2 | Way that hit |
| fill_valid_i | input | 1 | Fill strobe for one cycle |
| fill_idx_i | input | IDX_W | Line index being filled |
| fill_way_i | input | 2 | Way being filled |
| query_idx_i | input | IDX_W | Line whose victim is requested |
| lock_i | input | NUM_WAYS | Lock bits of the queried line, bit w for way w |
| victim_way_o | output | 2 | Selected victim way |
| all_locked_o | output | 1 | Every way of the queried line is locked |

## Verification
The bench drives one LRU line through a sequence of hits and fills that rebuilds every recency position. A wrong move-to-most-recent step would then name a recently touched way as victim. Same-cycle hit and fill on one line is aimed at the ordering rule: applying them in the wrong order evicts the wrong way. Lock patterns that cover the first, the middle and every preference position would expose a picker that stops at the first slot or lets a locked way through. Separate lines, a reset in mid-run, the two-way replace-history mode, the three-way counter wrap and the single-way case catch cross-line corruption, a sticky history, hits leaking into replace history and a counter that reaches way 3.

// File: rtl/victim_sel_pkg.sv
package victim_sel_pkg;

  typedef enum logic [1:0] {
    POL_RANDOM = 2'd0,
    POL_LRR    = 2'd1,
    POL_LRU    = 2'd2
  } policy_e;

  typedef logic [1:0]      way_t;
  typedef logic [3:0][1:0] order_t;  // [0] = first choice / least recent

  localparam int unsigned CODE_W = 5;

  function automatic int unsigned fact(input int unsigned n);
    int unsigned f;
    f = 1;
    for (int unsigned k = 2; k <= 4; k++) if (k <= n) f = f * k;
    return f;
  endfunction

  function automatic int unsigned lru_code_w(input int unsigned n);
    return (n <= 2) ? 1 : (n == 3) ? 3 : 5;
  endfunction

  // factorial-base rank -> ordering; out-of-range ranks read as identity
  function automatic order_t lru_decode(input int unsigned n, input logic [CODE_W-1:0] code);
    order_t ord;
    logic [3:0] used;
    int unsigned r, f, d, cnt;
    ord  = '0;
    used = '0;
    r    = 32'(code);
    if (r >= fact(n)) r = 0;
    for (int i = 0; i < 4; i++) begin
      if (i < int'(n)) begin
        f   = fact(n - 1 - i);
        d   = r / f;
        r   = r % f;
        cnt = 0;
        for (int w = 0; w < 4; w++) begin
          if (w < int'(n) && !used[w]) begin
            if (cnt == d) ord[i] = way_t'(w);
            cnt++;
          end
        end
        used[ord[i]] = 1'b1;
      end
    end
    return ord;
  endfunction

  function automatic logic [CODE_W-1:0] lru_encode(input int unsigned n, input order_t ord);
    int unsigned r, d;
    r = 0;
    for (int i = 0; i < 4; i++) begin
      if (i < int'(n)) begin
        d = 0;
        for (int j = 0; j < 4; j++)
          if (j > i && j < int'(n) && ord[j] < ord[i]) d++;
        r += d * fact(n - 1 - i);
      end
    end
    return r[CODE_W-1:0];
  endfunction

  // move way w to most recent
  function automatic order_t lru_touch(input int unsigned n, input order_t ord, input way_t w);
    order_t nxt;
    int unsigned k;
    nxt = ord;
    k   = 0;
    for (int i = 0; i < 4; i++) begin
      if (i < int'(n) && ord[i] != w) begin
        if (k < 4) nxt[k] = ord[i];
        k++;
      end
    end
    nxt[n-1] = w;
    return nxt;
  endfunction

endpackage

// File: rtl/victim_sel_rand.sv
module victim_sel_rand
  import victim_sel_pkg::*;
#(
  parameter int unsigned NUM_WAYS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output way_t cnt_o
);
  localparam int unsigned     CNT_W = (NUM_WAYS > 2) ? 2 : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_WAYS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = way_t'(cnt_q);
endmodule

// File: rtl/victim_sel_lru.sv
module victim_sel_lru
  import victim_sel_pkg::*;
#(
  parameter  int unsigned NUM_WAYS  = 4,
  parameter  int unsigned NUM_LINES = 16,
  localparam int unsigned IDX_W     = $clog2(NUM_LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_valid_i,
  input  logic [IDX_W-1:0] hit_idx_i,
  input  way_t             hit_way_i,
  input  logic             fill_valid_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  way_t             fill_way_i,
  input  logic [IDX_W-1:0] query_idx_i,
  output order_t           order_o
);
  localparam int unsigned HW = lru_code_w(NUM_WAYS);

  logic [HW-1:0]     hist_q [NUM_LINES];
  order_t            hit_nxt, fill_base, fill_nxt;
  logic [CODE_W-1:0] hit_code, fill_code;
  logic              hit_ok, fill_ok;

  assign hit_ok  = hit_valid_i  && (32'(hit_way_i)  < NUM_WAYS);
  assign fill_ok = fill_valid_i && (32'(fill_way_i) < NUM_WAYS);

  // fill applied after a same-line hit, so it ends up most recent
  always_comb begin
    hit_nxt   = lru_touch(NUM_WAYS, lru_decode(NUM_WAYS, CODE_W'(hist_q[hit_idx_i])), hit_way_i);
    fill_base = (hit_ok && hit_idx_i == fill_idx_i) ? hit_nxt
                : lru_decode(NUM_WAYS, CODE_W'(hist_q[fill_idx_i]));
    fill_nxt  = lru_touch(NUM_WAYS, fill_base, fill_way_i);
    hit_code  = lru_encode(NUM_WAYS, hit_nxt);
    fill_code = lru_encode(NUM_WAYS, fill_nxt);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NUM_LINES); i++) hist_q[i] <= '0;
    end else begin
      if (hit_ok)  hist_q[hit_idx_i]  <= hit_code[HW-1:0];
      if (fill_ok) hist_q[fill_idx_i] <= fill_code[HW-1:0];
    end
  end

  assign order_o = lru_decode(NUM_WAYS, CODE_W'(hist_q[query_idx_i]));
endmodule

// File: rtl/victim_sel_pick.sv
module victim_sel_pick
  import victim_sel_pkg::*;
#(
  parameter int unsigned NUM_WAYS = 4
) (
  input  order_t              order_i,
  input  logic [NUM_WAYS-1:0] lock_i,
  output way_t                victim_o,
  output logic                all_locked_o
);
  logic [3:0] lk;

  always_comb begin
    lk = '1;
    lk[NUM_WAYS-1:0] = lock_i;
    victim_o = order_i[0];
    for (int i = int'(NUM_WAYS) - 1; i >= 0; i--)
      if (!lk[order_i[i]]) victim_o = order_i[i];
    all_locked_o = &lock_i;
  end
endmodule

// File: rtl/victim_sel.sv
module victim_sel
  import victim_sel_pkg::*;
#(
  parameter  int unsigned NUM_WAYS  = 4,
  parameter  int unsigned NUM_LINES = 16,
  parameter  policy_e     POLICY    = POL_LRU,
  localparam int unsigned IDX_W     = $clog2(NUM_LINES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                hit_valid_i,
  input  logic [IDX_W-1:0]    hit_idx_i,
  input  logic [1:0]          hit_way_i,
  input  logic                fill_valid_i,
  input  logic [IDX_W-1:0]    fill_idx_i,
  input  logic [1:0]          fill_way_i,
  input  logic [IDX_W-1:0]    query_idx_i,
  input  logic [NUM_WAYS-1:0] lock_i,
  output logic [1:0]          victim_way_o,
  output logic                all_locked_o
);
  order_t order;

  if (NUM_WAYS <= 1) begin : g_one
    logic unused_one;
    assign unused_one = ^{clk_i, rst_ni, hit_valid_i, hit_idx_i, hit_way_i,
                          fill_valid_i, fill_idx_i, fill_way_i, query_idx_i};
    assign order = '0;
  end else if (POLICY == POL_RANDOM) begin : g_rand
    way_t cnt;
    logic unused_rand;
    assign unused_rand = ^{hit_valid_i, hit_idx_i, hit_way_i,
                           fill_valid_i, fill_idx_i, fill_way_i, query_idx_i};
    victim_sel_rand #(.NUM_WAYS(NUM_WAYS)) u_rand (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .cnt_o (cnt)
    );
    always_comb begin
      order = '0;
      for (int i = 0; i < 4; i++)
        if (i < int'(NUM_WAYS)) order[i] = way_t'((32'(cnt) + 32'(i)) % NUM_WAYS);
    end
  end else if (POLICY == POL_LRR) begin : g_lrr
    if (NUM_WAYS != 2) begin : g_bad
      $error("least-recently-replaced needs exactly two ways");
    end
    logic [NUM_LINES-1:0] vict_q;  // per line: way to evict next
    logic unused_lrr;
    assign unused_lrr = ^{hit_valid_i, hit_idx_i, hit_way_i};
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vict_q <= '0;
      else if (fill_valid_i && !fill_way_i[1]) vict_q[fill_idx_i] <= ~fill_way_i[0];
    end
    always_comb begin
      order    = '0;
      order[0] = {1'b0,  vict_q[query_idx_i]};
      order[1] = {1'b0, ~vict_q[query_idx_i]};
    end
  end else begin : g_lru
    victim_sel_lru #(.NUM_WAYS(NUM_WAYS), .NUM_LINES(NUM_LINES)) u_lru (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .hit_valid_i (hit_valid_i),
      .hit_idx_i   (hit_idx_i),
      .hit_way_i   (hit_way_i),
      .fill_valid_i(fill_valid_i),
      .fill_idx_i  (fill_idx_i),
      .fill_way_i  (fill_way_i),
      .query_idx_i (query_idx_i),
      .order_o     (order)
    );
  end

  victim_sel_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
    .order_i     (order),
    .lock_i      (lock_i),
    .victim_o    (victim_way_o),
    .all_locked_o(all_locked_o)
  );
endmodule

// File: rtl/victim_sel_chk.sv
module victim_sel_chk
  import victim_sel_pkg::*;
#(
  parameter  int unsigned NUM_WAYS  = 4,
  parameter  int unsigned NUM_LINES = 16,
  parameter  policy_e     POLICY    = POL_LRU,
  localparam int unsigned IDX_W     = $clog2(NUM_LINES)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                hit_valid_i,
  input logic [IDX_W-1:0]    hit_idx_i,
  input logic [1:0]          hit_way_i,
  input logic                fill_valid_i,
  input logic [IDX_W-1:0]    fill_idx_i,
  input logic [1:0]          fill_way_i,
  input logic [IDX_W-1:0]    query_idx_i,
  input logic [NUM_WAYS-1:0] lock_i,
  input logic [1:0]          victim_way_o,
  input logic                all_locked_o
);
  logic armed_q, touch, victim_locked, unused_chk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  assign touch = (hit_valid_i && hit_idx_i == query_idx_i) ||
                 (fill_valid_i && fill_idx_i == query_idx_i);
  assign victim_locked = |(lock_i & (NUM_WAYS'(1) << victim_way_o));
  assign unused_chk = ^{hit_way_i, fill_way_i, hit_idx_i, fill_idx_i};

  a_r8_victim_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(victim_way_o) < NUM_WAYS);

  a_r5_locked_skipped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !all_locked_o |-> !victim_locked);

  a_r6_full_returns_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_locked_o |-> victim_locked);

  if (POLICY != POL_RANDOM && NUM_WAYS >= 2) begin : g_hist
    a_r4_idle_line_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed_q && $past(!touch) && $stable(query_idx_i) && $stable(lock_i)
      |-> $stable(victim_way_o));

    a_r7_fill_not_victim: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed_q && $past(fill_valid_i && fill_idx_i == query_idx_i &&
                       32'(fill_way_i) < NUM_WAYS && lock_i == '0) &&
      $stable(query_idx_i) && lock_i == '0
      |-> victim_way_o != $past(fill_way_i));
  end

  if (POLICY == POL_LRU && NUM_WAYS >= 2) begin : g_lru
    a_r2_hit_not_victim: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed_q && $past(hit_valid_i && hit_idx_i == query_idx_i && lock_i == '0 &&
                       !(fill_valid_i && fill_idx_i == query_idx_i)) &&
      $stable(query_idx_i) && lock_i == '0
      |-> victim_way_o != $past(hit_way_i));
  end

  if (POLICY == POL_RANDOM && NUM_WAYS >= 2) begin : g_rand
    a_r8_rand_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed_q && $past(lock_i == '0) && lock_i == '0
      |-> 32'(victim_way_o) == (32'($past(victim_way_o)) + 1) % NUM_WAYS);
  end
endmodule

bind victim_sel victim_sel_chk #(
  .NUM_WAYS (NUM_WAYS),
  .NUM_LINES(NUM_LINES),
  .POLICY   (POLICY)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hit_valid_i (hit_valid_i),
  .hit_idx_i   (hit_idx_i),
  .hit_way_i   (hit_way_i),
  .fill_valid_i(fill_valid_i),
  .fill_idx_i  (fill_idx_i),
  .fill_way_i  (fill_way_i),
  .query_idx_i (query_idx_i),
  .lock_i      (lock_i),
  .victim_way_o(victim_way_o),
  .all_locked_o(all_locked_o)
);

// File: tb/victim_sel_tb_top.sv
`timescale 1ns/1ps
module victim_sel_tb_top;
  import victim_sel_pkg::*;

  typedef struct packed {
    logic       hv;
    logic [1:0] hw;
    logic       fv;
    logic [1:0] fw;
    logic [3:0] lk;
    logic [1:0] ev;
    logic       ea;
  } vec_t;

  // ops on line 3 of the 4-way LRU instance, victim checked after each
  localparam vec_t VECS [12] = '{
    '{1'b0, 2'd0, 1'b0, 2'd0, 4'b0000, 2'd0, 1'b0},
    '{1'b1, 2'd0, 1'b0, 2'd0, 4'b0000, 2'd1, 1'b0},
    '{1'b0, 2'd0, 1'b1, 2'd1, 4'b0000, 2'd2, 1'b0},
    '{1'b1, 2'd2, 1'b0, 2'd0, 4'b0000, 2'd3, 1'b0},
    '{1'b1, 2'd3, 1'b0, 2'd0, 4'b0000, 2'd0, 1'b0},
    '{1'b1, 2'd1, 1'b0, 2'd0, 4'b0000, 2'd0, 1'b0},
    '{1'b0, 2'd0, 1'b0, 2'd0, 4'b0001, 2'd2, 1'b0},
    '{1'b0, 2'd0, 1'b0, 2'd0, 4'b0101, 2'd3, 1'b0},
    '{1'b0, 2'd0, 1'b0, 2'd0, 4'b1111, 2'd0, 1'b1},
    '{1'b1, 2'd0, 1'b1, 2'd2, 4'b0000, 2'd3, 1'b0},
    '{1'b1, 2'd3, 1'b0, 2'd0, 4'b0000, 2'd1, 1'b0},
    '{1'b0, 2'd0, 1'b0, 2'd0, 4'b0010, 2'd0, 1'b0}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  // 4-way LRU
  logic       hv = 0, fv = 0;
  logic [1:0] hw = 0, fw = 0;
  logic [3:0] hidx = 0, fidx = 0, qidx = 4'd3, lock = 0;
  logic [1:0] vic;
  logic       all;
  // 2-way LRR
  logic       l_hv = 0, l_fv = 0;
  logic [1:0] l_hw = 0, l_fw = 0, l_lock = 0, l_vic;
  logic [2:0] l_hidx = 0, l_fidx = 0, l_qidx = 3'd2;
  logic       l_all;
  // 3-way random
  logic [2:0] r_lock = 0;
  logic [1:0] r_vic;
  logic       r_all;
  // 1-way
  logic       o_hv = 0, o_lock = 0, o_all;
  logic [1:0] o_vic;

  victim_sel #(.NUM_WAYS(4), .NUM_LINES(16), .POLICY(POL_LRU)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .hit_valid_i(hv), .hit_idx_i(hidx), .hit_way_i(hw),
    .fill_valid_i(fv), .fill_idx_i(fidx), .fill_way_i(fw), .query_idx_i(qidx),
    .lock_i(lock), .victim_way_o(vic), .all_locked_o(all));

  victim_sel #(.NUM_WAYS(2), .NUM_LINES(8), .POLICY(POL_LRR)) dut_lrr_i (
    .clk_i(clk), .rst_ni(rst_ni), .hit_valid_i(l_hv), .hit_idx_i(l_hidx), .hit_way_i(l_hw),
    .fill_valid_i(l_fv), .fill_idx_i(l_fidx), .fill_way_i(l_fw), .query_idx_i(l_qidx),
    .lock_i(l_lock), .victim_way_o(l_vic), .all_locked_o(l_all));

  victim_sel #(.NUM_WAYS(3), .NUM_LINES(8), .POLICY(POL_RANDOM)) dut_rnd_i (
    .clk_i(clk), .rst_ni(rst_ni), .hit_valid_i(1'b0), .hit_idx_i(3'd0), .hit_way_i(2'd0),
    .fill_valid_i(1'b0), .fill_idx_i(3'd0), .fill_way_i(2'd0), .query_idx_i(3'd0),
    .lock_i(r_lock), .victim_way_o(r_vic), .all_locked_o(r_all));

  victim_sel #(.NUM_WAYS(1), .NUM_LINES(4), .POLICY(POL_LRU)) dut_one_i (
    .clk_i(clk), .rst_ni(rst_ni), .hit_valid_i(o_hv), .hit_idx_i(2'd1), .hit_way_i(2'd0),
    .fill_valid_i(o_hv), .fill_idx_i(2'd1), .fill_way_i(2'd0), .query_idx_i(2'd1),
    .lock_i(o_lock), .victim_way_o(o_vic), .all_locked_o(o_all));

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic op(input logic h, input logic [1:0] hwy, input logic [3:0] hi,
                    input logic f, input logic [1:0] fwy, input logic [3:0] fi);
    @(negedge clk);
    hv = h; hw = hwy; hidx = hi; fv = f; fw = fwy; fidx = fi;
    @(posedge clk); #1;
    hv = 0; fv = 0;
    #4;
  endtask

  task automatic lop(input logic h, input logic [1:0] hwy, input logic f,
                     input logic [1:0] fwy, input logic [2:0] fi);
    @(negedge clk);
    l_hv = h; l_hw = hwy; l_hidx = 3'd2; l_fv = f; l_fw = fwy; l_fidx = fi;
    @(posedge clk); #1;
    l_hv = 0; l_fv = 0;
    #4;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int e;
    string req;
    // R1: reset state while reset is held
    #35;
    chk("R1 lru", vic, 2'd0);
    chk("R1 flag", {1'b0, all}, 2'd0);
    chk("R1 lrr", l_vic, 2'd0);
    chk("R1 rnd", r_vic, 2'd0);
    @(negedge clk); rst_ni = 1'b1;
    #2;
    qidx = 4'd0; #1;
    chk("R1 line0", vic, 2'd0);
    qidx = 4'd3;

    // R2 R3 R5 R6 vector walk on line 3
    for (int k = 0; k < 12; k++) begin
      lock = VECS[k].lk;
      op(VECS[k].hv, VECS[k].hw, 4'd3, VECS[k].fv, VECS[k].fw, 4'd3);
      req = (VECS[k].lk == 4'hf) ? "R6" : (VECS[k].lk != 0) ? "R5" :
            (VECS[k].hv && VECS[k].fv) ? "R3" : "R2";
      chk(req, vic, VECS[k].ev);
      chk({req, " flag"}, {1'b0, all}, {1'b0, VECS[k].ea});
    end
    lock = 0;

    // R4: other lines untouched, two lines updated in one cycle
    qidx = 4'd5; #1;
    chk("R4 idle line", vic, 2'd0);
    op(1'b1, 2'd0, 4'd5, 1'b1, 2'd0, 4'd3);
    chk("R4 line5", vic, 2'd1);
    qidx = 4'd3; #1;
    chk("R4 line3", vic, 2'd1);
    qidx = 4'd7; #1;
    chk("R4 line7", vic, 2'd0);

    // R1: reset in mid-run clears history
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    qidx = 4'd3; #2;
    chk("R1 after reset", vic, 2'd0);
    qidx = 4'd5; #1;
    chk("R1 after reset line5", vic, 2'd0);
    chk("R1 lrr after reset", l_vic, 2'd0);

    // R7: least-recently-replaced on 2 ways
    lop(1'b0, 2'd0, 1'b1, 2'd0, 3'd2);
    chk("R7 fill0", l_vic, 2'd1);
    lop(1'b1, 2'd1, 1'b0, 2'd0, 3'd2);
    chk("R7 hit ignored", l_vic, 2'd1);
    lop(1'b0, 2'd0, 1'b1, 2'd1, 3'd2);
    chk("R7 fill1", l_vic, 2'd0);
    lop(1'b0, 2'd0, 1'b1, 2'd0, 3'd4);
    chk("R4 lrr other line", l_vic, 2'd0);
    l_lock = 2'b01; #1;
    chk("R5 lrr lock", l_vic, 2'd1);
    l_lock = 2'b11; #1;
    chk("R6 lrr all", l_vic, 2'd0);
    chk("R6 lrr flag", {1'b0, l_all}, 2'd1);
    l_lock = 2'b00;

    // R8: 3-way counter rotation, lock skip
    @(negedge clk);
    e = int'(r_vic);
    chk("R8 base in range", {1'b0, r_vic < 2'd3}, 2'd1);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      e = (e + 1) % 3;
      chk("R8 step", r_vic, 2'(e));
    end
    r_lock = 3'b010;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      e = (e + 1) % 3;
      chk("R8 lock skip", r_vic, (e == 1) ? 2'd2 : 2'(e));
    end
    r_lock = 3'b111;
    @(negedge clk);
    e = (e + 1) % 3;
    chk("R6 rnd all", r_vic, 2'(e));
    chk("R6 rnd flag", {1'b0, r_all}, 2'd1);
    r_lock = 3'b000;

    // R9: single way
    @(negedge clk); o_hv = 1'b1;
    @(negedge clk);
    chk("R9 one way", o_vic, 2'd0);
    o_hv = 1'b0; o_lock = 1'b1; #1;
    chk("R9 one locked", o_vic, 2'd0);
    chk("R9 one flag", {1'b0, o_all}, 2'd1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule